// File: doc/BRIEF.md
# Dual-Loop Beat-Tag PI Controller

This block is the loop filter of a dual-mixer clock-recovery scheme. It takes two streams of 32-bit beat timestamps, each with a one-cycle strobe. One stream comes from the recovered reference clock. The other comes from the main oscillator.

From every reference timestamp it forms a period error. That error drives a proportional-integral loop, which produces a frequency word for the helper oscillator. Once a reference timestamp and a main timestamp are both fresh, it forms a phase error from them. That error drives a second, independent PI loop, which produces a frequency word for the main oscillator.

Each word is the sum of a base offset, six times the error and the running integrator. It is clamped to a symmetric limit and issued as a signed 24-bit value under a valid/ready handshake. A downstream transport serialises the words to the oscillators.

Top module: `tag_pi_loop`

## Requirements
- R1: On an accepted reference strobe, the helper integrator grows by 2·e. The helper word is base + 6·e + (new integrator), where e is the wrapped low 15 bits of the two's-complement negation of `ref_tag`.
- R2: Error wrapping: a 15-bit residue strictly above 16384 has 32768 subtracted. A residue of exactly 16384 stays +16384, so errors lie in −16383..+16384.
- R3: The main loop updates only when both a reference tag and a main tag are fresh. Its error is the wrapped low 15 bits of (main − reference) in 32-bit modular arithmetic. Each update clears both fresh flags, and a later main strobe replaces a pending main tag.
- R4: When both strobes arrive in the same cycle, the reference tag is taken first. Both loops update in that cycle, and the main error uses the new reference tag.
- R5: Each word is clamped to the range −8161512..+8161512.
- R6: The integrators are 32-bit signed and saturate rather than wrap.
- R7: A `clr` pulse zeroes both integrators, both stored tags and both fresh flags. It also issues a word of 0 on both outputs, valid in the next cycle.
- R8: While `loop_en` is low, strobes are ignored and `base_ofs` is captured every cycle. While `loop_en` is high, the captured base is held.
- R9: A valid word stays valid until ready is seen. A newer update replaces a pending word rather than queueing behind it.
- R10: After reset both valids are low and both words are 0.
- R11: A word caused by a strobe is presented in the cycle after the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_en | input | 1 | Loop enable; low captures the base offset and ignores strobes |
| clr | input | 1 | Loop clear; zeroes state and issues zero words |
| base_ofs | input | 24 | Signed base frequency offset |
| ref_tag | input | 32 | Reference beat timestamp |
| ref_stb | input | 1 | Reference timestamp strobe |
| main_tag | input | 32 | Main oscillator beat timestamp |
| main_stb | input | 1 | Main timestamp strobe |
| hlp_word | output | 24 | Signed helper frequency word |
| hlp_valid | output | 1 | Helper word valid |
| hlp_ready | input | 1 | Helper word accepted |
| mn_word | output | 24 | Signed main frequency word |
| mn_valid | output | 1 | Main word valid |
| mn_ready | input | 1 | Main word accepted |

## Verification
A corrupted integrator shows at the ports in the first word after the next strobe, because every word carries the full integrator value. A saturation fault only shows after tens of thousands of same-sign updates, when the next opposite-sign error flips the output to the far clamp. A wrong fresh flag shows as a main word that appears a strobe early or late, or that uses a stale tag. The bench orders strobes to expose each of these cases: reference first, main first, coincident, and repeated main.

// File: rtl/tag_pi_loop.sv
module tag_pi_loop #(
  parameter int TW    = 32,
  parameter int FW    = 24,
  parameter int PB    = 15,
  parameter int IW    = 32,
  parameter int KP    = 6,
  parameter int KI    = 2,
  parameter int LIMIT = 8161512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          loop_en,
  input  logic          clr,
  input  logic [FW-1:0] base_ofs,
  input  logic [TW-1:0] ref_tag,
  input  logic          ref_stb,
  input  logic [TW-1:0] main_tag,
  input  logic          main_stb,
  output logic [FW-1:0] hlp_word,
  output logic          hlp_valid,
  input  logic          hlp_ready,
  output logic [FW-1:0] mn_word,
  output logic          mn_valid,
  input  logic          mn_ready
);
  localparam int EW = PB + 1;
  localparam int SW = ((IW > FW) ? IW : FW) + 4;
  localparam logic [PB-1:0] HALF = PB'(1) << (PB - 1);
  localparam logic signed [SW-1:0] LIMS = SW'(LIMIT);
  localparam logic signed [IW+1:0] IMAX = {3'b000, {(IW-1){1'b1}}};
  localparam logic signed [IW+1:0] IMIN = {3'b111, {(IW-1){1'b0}}};

  function automatic logic signed [EW-1:0] wrap_err(input logic [PB-1:0] r);
    // {1,r} equals r - 2^PB in EW-bit two's complement
    return (r > HALF) ? {1'b1, r} : {1'b0, r};
  endfunction

  function automatic logic signed [IW-1:0] sat_acc(input logic signed [IW-1:0] a,
                                                   input logic signed [EW-1:0] e);
    logic signed [IW+1:0] s;
    s = $signed({{2{a[IW-1]}}, a}) +
        $signed({{(IW+2-EW){e[EW-1]}}, e}) * $signed((IW+2)'(KI));
    if (s > IMAX)      s = IMAX;
    else if (s < IMIN) s = IMIN;
    return s[IW-1:0];
  endfunction

  function automatic logic [FW-1:0] pi_word(input logic signed [FW-1:0] b,
                                            input logic signed [EW-1:0] e,
                                            input logic signed [IW-1:0] i);
    logic signed [SW-1:0] s;
    s = $signed({{(SW-FW){b[FW-1]}}, b}) +
        $signed({{(SW-EW){e[EW-1]}}, e}) * $signed(SW'(KP)) +
        $signed({{(SW-IW){i[IW-1]}}, i});
    if (s > LIMS)       return FW'(LIMIT);
    else if (s < -LIMS) return FW'(-LIMIT);
    else                return s[FW-1:0];
  endfunction

  logic [TW-1:0]        ref_q, mn_q;
  logic                 ref_rdy, mn_rdy;
  logic signed [FW-1:0] base_q;
  logic signed [IW-1:0] hint, mint;

  wire ref_acc = loop_en & ref_stb;
  wire mn_acc  = loop_en & main_stb;
  wire [TW-1:0] ref_n = ref_acc ? ref_tag : ref_q;
  wire [TW-1:0] mn_n  = mn_acc ? main_tag : mn_q;
  wire pair = (ref_rdy | ref_acc) & (mn_rdy | mn_acc);

  wire [TW-1:0] neg_ref  = '0 - ref_tag;
  wire [TW-1:0] ph_diff  = mn_n - ref_n;
  wire signed [EW-1:0] e_h = wrap_err(neg_ref[PB-1:0]);
  wire signed [EW-1:0] e_m = wrap_err(ph_diff[PB-1:0]);
  wire signed [IW-1:0] hint_n = sat_acc(hint, e_h);
  wire signed [IW-1:0] mint_n = sat_acc(mint, e_m);
  wire [FW-1:0] hw = pi_word(base_q, e_h, hint_n);
  wire [FW-1:0] mw = pi_word(base_q, e_m, mint_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0; mn_q <= '0; ref_rdy <= 1'b0; mn_rdy <= 1'b0;
      base_q <= '0; hint <= '0; mint <= '0;
      hlp_word <= '0; hlp_valid <= 1'b0; mn_word <= '0; mn_valid <= 1'b0;
    end else begin
      if (!loop_en) base_q <= base_ofs;
      if (clr) begin
        ref_q <= '0; mn_q <= '0; ref_rdy <= 1'b0; mn_rdy <= 1'b0;
        hint <= '0; mint <= '0;
        hlp_word <= '0; hlp_valid <= 1'b1; mn_word <= '0; mn_valid <= 1'b1;
      end else begin
        hlp_valid <= hlp_valid & ~hlp_ready;
        mn_valid  <= mn_valid & ~mn_ready;
        if (ref_acc) begin
          ref_q <= ref_tag; hint <= hint_n; hlp_word <= hw; hlp_valid <= 1'b1;
        end
        if (mn_acc) mn_q <= main_tag;
        if (pair) begin
          mint <= mint_n; mn_word <= mw; mn_valid <= 1'b1;
          ref_rdy <= 1'b0; mn_rdy <= 1'b0;
        end else begin
          ref_rdy <= ref_rdy | ref_acc;
          mn_rdy  <= mn_rdy | mn_acc;
        end
      end
    end
  end
endmodule

// File: rtl/tag_pi_loop_chk.sv
module tag_pi_loop_chk #(
  parameter int FW    = 24,
  parameter int LIMIT = 8161512
) (
  input logic          clk,
  input logic          rst_n,
  input logic          loop_en,
  input logic          clr,
  input logic          ref_stb,
  input logic          main_stb,
  input logic [FW-1:0] hlp_word,
  input logic          hlp_valid,
  input logic          hlp_ready,
  input logic [FW-1:0] mn_word,
  input logic          mn_valid,
  input logic          mn_ready
);
  localparam logic signed [FW-1:0] LW = FW'(LIMIT);

  p_clamp_hlp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hlp_valid |-> ($signed(hlp_word) <= LW && $signed(hlp_word) >= -LW));
  p_clamp_mn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mn_valid |-> ($signed(mn_word) <= LW && $signed(mn_word) >= -LW));
  p_zero_words_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (hlp_valid && mn_valid && hlp_word == '0 && mn_word == '0));
  p_hold_hlp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hlp_valid && !hlp_ready) |=> hlp_valid);
  p_hold_mn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mn_valid && !mn_ready) |=> mn_valid);
  p_ignore_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_en && !clr && !hlp_valid && !mn_valid) |=> (!hlp_valid && !mn_valid));
  p_issue_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && ref_stb && !clr) |=> hlp_valid);
  p_no_main_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_stb && !main_stb && !clr && !mn_valid) |=> !mn_valid);
endmodule

bind tag_pi_loop tag_pi_loop_chk #(.FW(FW), .LIMIT(LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .clr(clr),
  .ref_stb(ref_stb), .main_stb(main_stb),
  .hlp_word(hlp_word), .hlp_valid(hlp_valid), .hlp_ready(hlp_ready),
  .mn_word(mn_word), .mn_valid(mn_valid), .mn_ready(mn_ready)
);

// File: tb/tb_tag_pi_loop.sv
`timescale 1ns/1ps
module tb_tag_pi_loop;
  localparam longint LIM = 8161512;
  logic clk = 0, rst_n = 0, loop_en = 0, clr = 0;
  logic [23:0] base_ofs = '0;
  logic [31:0] ref_tag = '0, main_tag = '0;
  logic ref_stb = 0, main_stb = 0, hlp_ready = 1, mn_ready = 1;
  logic [23:0] hlp_word, mn_word;
  logic hlp_valid, mn_valid;
  int n_chk = 0, n_fail = 0;
  longint hI = 0, mI = 0, B = 0;

  tag_pi_loop dut (.*);

  always #2.5 clk = ~clk;

  // {ref tag, expected wrapped period error}
  localparam longint HTAB [8][2] = '{
    '{0, 0}, '{1, -1}, '{32'h7FFF, 1}, '{32'h4000, 16384},
    '{32'h3FFF, -16383}, '{32'h12345678, 10632}, '{32'hFFFFFFF0, 16}, '{32'h4001, 16383}};
  // {ref tag, main tag, period error, phase error}
  localparam longint MTAB [5][4] = '{
    '{32'h100, 32'h105, -256, 5}, '{5, 0, -5, -5}, '{0, 32'h4000, 0, 16384},
    '{0, 32'h4001, 0, -16383}, '{32'hFFFFFFFF, 1, 1, 2}};

  function automatic longint sat32(longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction
  function automatic longint clampw(longint v);
    if (v > LIM) return LIM;
    if (v < -LIM) return -LIM;
    return v;
  endfunction
  function automatic longint h_upd(longint e);
    hI = sat32(hI + 2*e); return clampw(B + 6*e + hI);
  endfunction
  function automatic longint m_upd(longint e);
    mI = sat32(mI + 2*e); return clampw(B + 6*e + mI);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask
  task automatic chk_h(string req, longint exp);
    chk(hlp_valid && longint'($signed(hlp_word)) == exp, req, longint'($signed(hlp_word)), exp);
  endtask
  task automatic chk_m(string req, longint exp);
    chk(mn_valid && longint'($signed(mn_word)) == exp, req, longint'($signed(mn_word)), exp);
  endtask

  task automatic step(bit rs, bit ms, logic [31:0] rt, logic [31:0] mt);
    @(negedge clk); ref_stb = rs; main_stb = ms; ref_tag = rt; main_tag = mt;
    @(posedge clk); #1; ref_stb = 0; main_stb = 0;
  endtask
  task automatic do_clr();
    @(negedge clk); clr = 1;
    @(posedge clk); #1; clr = 0; hI = 0; mI = 0;
  endtask
  task automatic set_base(longint v);
    @(negedge clk); loop_en = 0; base_ofs = 24'(v);
    @(negedge clk); loop_en = 1; B = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R10 reset state
    #12;
    chk(!hlp_valid && !mn_valid && hlp_word == 0 && mn_word == 0, "R10", hlp_valid, 0);
    rst_n = 1;
    set_base(1000);
    @(negedge clk); base_ofs = 24'd55555;
    // R7 clear issues zero words
    do_clr();
    chk(hlp_valid && mn_valid && hlp_word == 0 && mn_word == 0, "R7 zero words", hlp_word, 0);

    // R1 R2 R11 helper loop table, base held at 1000 (R8)
    for (int i = 0; i < 8; i++) begin
      step(1, 0, HTAB[i][0][31:0], 0);
      chk_h("R1/R2/R11 helper word", h_upd(HTAB[i][1]));
      chk(!mn_valid, "R3 no main without main tag", mn_valid, 0);
    end

    // R3 main loop table
    do_clr();
    for (int i = 0; i < 5; i++) begin
      step(1, 0, MTAB[i][0][31:0], 0);
      chk_h("R1 helper in pair", h_upd(MTAB[i][2]));
      chk(!mn_valid, "R3 wait for main tag", mn_valid, 0);
      step(0, 1, 0, MTAB[i][1][31:0]);
      chk_m("R3 main word", m_upd(MTAB[i][3]));
      chk(!hlp_valid, "R3 main strobe leaves helper", hlp_valid, 0);
    end

    // R4 coincident strobes: reference first
    do_clr();
    step(1, 1, 32'h20, 32'h30);
    chk_h("R4 helper", h_upd(-32));
    chk_m("R4 main uses new ref", m_upd(16));

    // R3 main first, latest main tag wins, flags then cleared
    do_clr();
    step(0, 1, 0, 32'h1000);
    chk(!mn_valid, "R3 lone main", mn_valid, 0);
    step(0, 1, 0, 32'h2000);
    chk(!mn_valid, "R3 second main", mn_valid, 0);
    step(1, 0, 32'h1800, 0);
    chk_h("R3 helper", h_upd(-6144));
    chk_m("R3 latest main tag", m_upd(2048));
    step(1, 0, 32'h10, 0);
    chk_h("R3 helper after pair", h_upd(-16));
    chk(!mn_valid, "R3 flags cleared", mn_valid, 0);

    // R8 disabled loop ignores strobes, base captured while low
    @(negedge clk); loop_en = 0; base_ofs = -24'sd2000;
    step(1, 1, 32'h123, 32'h456);
    chk(!hlp_valid && !mn_valid, "R8 strobes ignored", hlp_valid, 0);
    @(negedge clk); loop_en = 1; B = -2000; base_ofs = 24'd7;
    do_clr();
    step(1, 0, 0, 0);
    chk_h("R8 base held", h_upd(0));

    // R5 clamp both signs
    set_base(8000000); do_clr();
    step(1, 0, 32'h4000, 0); chk_h("R5 below limit", h_upd(16384));
    step(1, 0, 32'h4000, 0); chk_h("R5 positive clamp", LIM);
    set_base(-8000000); do_clr();
    step(1, 0, 32'h3FFF, 0); void'(h_upd(-16383));
    step(1, 0, 32'h3FFF, 0); chk_h("R5 negative clamp", -LIM);

    // R9 handshake: hold and replace
    set_base(0); do_clr();
    @(negedge clk); hlp_ready = 0;
    step(1, 0, 32'h7FFF, 0); void'(h_upd(1));
    step(1, 0, 32'h7FFE, 0);
    chk_h("R9 latest replaces", h_upd(2));
    step(0, 0, 0, 0);
    chk_h("R9 held", 18);
    @(negedge clk); hlp_ready = 1;
    @(posedge clk); #1;
    chk(!hlp_valid, "R9 accepted", hlp_valid, 0);

    // R6 integrator saturation
    do_clr();
    @(negedge clk); ref_tag = 32'h4000; ref_stb = 1;
    repeat (65540) @(posedge clk);
    @(negedge clk); ref_stb = 0;
    for (int i = 0; i < 65540; i++) void'(h_upd(16384));
    step(1, 0, 32'h3FFF, 0);
    chk_h("R6 saturated integrator", h_upd(-16383));
    chk(longint'($signed(hlp_word)) == LIM, "R6 no wrap", longint'($signed(hlp_word)), LIM);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule